// File: doc/BRIEF.md
# Collision Jam and Retry Backoff Controller

This block runs the collision side of a half-duplex Ethernet transmitter. Each clock cycle is one bit time. A frame attempt starts with `tx_start`. The block then drives the preamble and the start-of-frame delimiter on the line itself. After that it hands the line to the MAC data path by raising `mac_sel`, and keeps it there until the MAC reports the end of the frame on `tx_done`.

If `col_det` rises during an attempt, the block sends a burst of all-ones jam bits and releases the line. When the collision comes during the preamble, the preamble and delimiter are finished first. A slot timer starts at the first preamble bit and sorts each collision:

- **Late collision:** the frame is dropped. An out-of-window status bit is set and a transmit-error pulse is raised.
- **Collision inside the first slot:** a retry counter advances. The block draws a truncated binary exponential backoff from an LFSR and asks the memory side to rewind the frame (`rtx_req` / `rtx_ack`). It starts the next attempt on its own once the backoff has run out and the rewind has been acknowledged.
- **Sixteenth collision:** the frame is dropped at once. An excessive-collision status bit is set and no backoff is run.

Top module: `col_backoff_ctrl`

## Requirements
- R1: During and right after reset, `line_en`, `mac_sel`, `rtx_req`, `txe`, `tx_ok`, `st_owc`, `st_exc` are 0 and `attempt_cnt` is 0.
- R2: One cycle after `tx_start` is sampled in idle, the block drives 64 preamble bits with `line_en` high. Bit i (from 0) is 1 for even i and 0 for odd i, except bit 63, which is 1. After bit 63, `mac_sel` is 1.
- R3: A collision seen during the preamble does not cut it short. All 64 bits are sent, then 32 cycles with `line_en`=1, `line_bit`=1 and `mac_sel`=0, then `line_en` falls.
- R4: A collision seen while `mac_sel` is 1 starts the 32-cycle all-ones jam in the next cycle, and `line_en` falls after it.
- R5: A collision seen fewer than SLOT_BITS bit times after the first preamble bit is in-window. After the jam, `attempt_cnt` has risen by one to n, `rtx_req` is 1, and `backoff_slots` is below 2^min(n, BACKOFF_CAP).
- R6: With `rtx_ack` held high, `line_en` stays low for exactly `backoff_slots`*SLOT_BITS+1 cycles after the jam. A new preamble then begins without another `tx_start`.
- R7: No new attempt starts before `rtx_ack` has been seen. `rtx_req` stays high while it is missing, and the preamble starts in the cycle after the edge that samples it, once the backoff has expired.
- R8: A collision seen SLOT_BITS or more bit times after the first preamble bit is out-of-window. After the jam, `st_owc` is 1, `txe` pulses for one cycle, `rtx_req` stays 0, `attempt_cnt` is 0, and no new attempt follows.
- R9: The sixteenth in-window collision of a frame ends it after the jam with `st_exc` = 1, a one-cycle `txe` pulse, `rtx_req` = 0, `attempt_cnt` = 0, and no backoff.
- R10: `tx_done` while `mac_sel` is 1 ends the frame. In the next cycle `line_en` is 0, `tx_ok` pulses and `attempt_cnt` is 0.
- R11: `st_owc` and `st_exc` hold their value until the next `tx_start` is accepted, which clears them.
- R12: When `col_det` and `tx_done` arrive in the same cycle, the collision wins: the jam follows and `tx_ok` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-time clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_start | input | 1 | Start a new frame (accepted only when idle) |
| tx_done | input | 1 | MAC has sent the last bit of the frame |
| col_det | input | 1 | Collision detected on the medium |
| rtx_ack | input | 1 | Memory side has flushed, rewound and released abort |
| line_en | output | 1 | Transmitter drives the line |
| line_bit | output | 1 | Serial bit from this block (preamble or jam) |
| mac_sel | output | 1 | The MAC data path owns the line bit |
| rtx_req | output | 1 | Request to rewind the frame for retransmission |
| txe | output | 1 | One-cycle transmit-error pulse on abort |
| tx_ok | output | 1 | One-cycle pulse on successful completion |
| st_owc | output | 1 | Out-of-window collision status |
| st_exc | output | 1 | Excessive-collision status |
| attempt_cnt | output | $clog2(ATTEMPT_LIMIT) | In-window collisions so far in this frame |
| backoff_slots | output | BACKOFF_CAP | Slots drawn for the current backoff |

## Verification
The bench places collisions at both sides of the slot boundary, at bit times SLOT_BITS-1 and SLOT_BITS. A design with an off-by-one slot timer would either retry a late collision or drop a legal one. It collides on preamble bit 0 and bit 10 and checks the whole pattern and the jam that follows. A design that jams at once would truncate the delimiter. It drives sixteen back-to-back collisions, so a limit compare that is off by one would back off once more or abort one collision early. It also withholds the rewind acknowledge for longer than any possible backoff, and raises done together with a collision, to catch a block that restarts early or reports success on a collided frame.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_PRE  = 3'd1,
      ST_DATA = 3'd2,
      ST_JAM  = 3'd3,
      ST_BACK = 3'd4
   } cbc_state_e;

   // Preamble bytes go out least significant bit first: 0x55 gives 1,0,1,0...
   // and the closing 0xD5 gives the same run with a final 1.
   function automatic logic preamble_bit(input int unsigned idx, input int unsigned total);
      if (idx == total - 1)
         return 1'b1;
      return ((idx % 2) == 0) ? 1'b1 : 1'b0;
   endfunction

   function automatic int unsigned cap_exp(input int unsigned n, input int unsigned cap);
      return (n < cap) ? n : cap;
   endfunction

endpackage

// File: rtl/cbc_slot_timer.sv
module cbc_slot_timer #(
   parameter int unsigned SLOT_BITS = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic advance,
   output logic in_window
);
   localparam int unsigned CW = $clog2(SLOT_BITS + 1);
   localparam logic [CW-1:0] SAT = CW'(SLOT_BITS);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (restart)
         cnt_q <= '0;
      else if (advance && (cnt_q != SAT))
         cnt_q <= cnt_q + 1'b1;
   end

   assign in_window = (cnt_q < SAT);
endmodule

// File: rtl/cbc_lfsr.sv
module cbc_lfsr #(
   parameter int unsigned      LFSR_W = 16,
   parameter int unsigned      OUT_W  = 10,
   parameter logic [31:0]      SEED   = 32'h0000_ACE1
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [OUT_W-1:0] rnd
);
   logic [LFSR_W-1:0] s_q;
   logic              fb;

   generate
      if (LFSR_W == 16) begin : g_w16
         assign fb = s_q[15] ^ s_q[13] ^ s_q[12] ^ s_q[10];
      end else if (LFSR_W == 24) begin : g_w24
         assign fb = s_q[23] ^ s_q[22] ^ s_q[21] ^ s_q[16];
      end else if (LFSR_W == 32) begin : g_w32
         assign fb = s_q[31] ^ s_q[21] ^ s_q[1] ^ s_q[0];
      end else begin : g_bad_width
         $error("cbc_lfsr: LFSR_W must be 16, 24 or 32");
      end
      if (OUT_W > LFSR_W) begin : g_bad_out
         $error("cbc_lfsr: OUT_W exceeds LFSR_W");
      end
      if (SEED[LFSR_W-1:0] == '0) begin : g_bad_seed
         $error("cbc_lfsr: SEED must be nonzero in the low LFSR_W bits");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         s_q <= SEED[LFSR_W-1:0];
      else
         s_q <= {s_q[LFSR_W-2:0], fb};
   end

   assign rnd = s_q[OUT_W-1:0];
endmodule

// File: rtl/cbc_backoff_timer.sv
module cbc_backoff_timer #(
   parameter int unsigned SLOT_BITS   = 512,
   parameter int unsigned BACKOFF_CAP = 10
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load,
   input  logic [BACKOFF_CAP-1:0] slots,
   input  logic                   run,
   output logic                   expired
);
   localparam int unsigned BW = $clog2(SLOT_BITS) + BACKOFF_CAP + 1;

   logic [BW-1:0] cnt_q;
   logic [BW-1:0] load_val;

   assign load_val = BW'(slots) * BW'(SLOT_BITS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (run && (cnt_q != '0))
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/col_backoff_ctrl.sv
module col_backoff_ctrl
   import cbc_pkg::*;
#(
   parameter int unsigned SLOT_BITS     = 512,
   parameter int unsigned PRE_BYTES     = 8,
   parameter int unsigned JAM_BITS      = 32,
   parameter int unsigned ATTEMPT_LIMIT = 16,
   parameter int unsigned BACKOFF_CAP   = 10,
   parameter int unsigned LFSR_W        = 16,
   parameter logic [31:0] LFSR_SEED     = 32'h0000_ACE1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             tx_start,
   input  logic                             tx_done,
   input  logic                             col_det,
   input  logic                             rtx_ack,
   output logic                             line_en,
   output logic                             line_bit,
   output logic                             mac_sel,
   output logic                             rtx_req,
   output logic                             txe,
   output logic                             tx_ok,
   output logic                             st_owc,
   output logic                             st_exc,
   output logic [$clog2(ATTEMPT_LIMIT)-1:0] attempt_cnt,
   output logic [BACKOFF_CAP-1:0]           backoff_slots
);
   localparam int unsigned PRE_BITS = PRE_BYTES * 8;
   localparam int unsigned SEQ_MAX  = (PRE_BITS > JAM_BITS) ? PRE_BITS : JAM_BITS;
   localparam int unsigned IDX_W    = $clog2(SEQ_MAX);
   localparam int unsigned ATT_W    = $clog2(ATTEMPT_LIMIT);
   localparam logic [IDX_W-1:0] PRE_LAST = IDX_W'(PRE_BITS - 1);
   localparam logic [IDX_W-1:0] JAM_LAST = IDX_W'(JAM_BITS - 1);
   localparam logic [ATT_W:0]   ATT_STOP = (ATT_W + 1)'(ATTEMPT_LIMIT);

   generate
      if (PRE_BITS > SLOT_BITS) begin : g_bad_slot
         $error("col_backoff_ctrl: preamble must fit inside one slot");
      end
      if (ATTEMPT_LIMIT < 2) begin : g_bad_limit
         $error("col_backoff_ctrl: ATTEMPT_LIMIT must be at least 2");
      end
      if (BACKOFF_CAP < 1 || BACKOFF_CAP > LFSR_W) begin : g_bad_cap
         $error("col_backoff_ctrl: BACKOFF_CAP out of range");
      end
      if (JAM_BITS < 2 || PRE_BYTES < 1) begin : g_bad_seq
         $error("col_backoff_ctrl: jam and preamble lengths too short");
      end
   endgenerate

   cbc_state_e       state_q, state_d;
   logic [IDX_W-1:0] idx_q;
   logic             col_pend_q, owc_pend_q, ack_seen_q;
   logic [ATT_W-1:0] att_q;
   logic             st_owc_q, st_exc_q, txe_q, tx_ok_q;
   logic [BACKOFF_CAP-1:0] slots_q;

   logic             in_window, bo_expired, enter_pre;
   logic             pre_last, jam_last;
   logic             frame_ok, abort_owc, abort_exc, back_load;
   logic [ATT_W:0]   att_next;
   logic [BACKOFF_CAP-1:0] lfsr_bits, draw_mask, draw_val;
   int unsigned      draw_exp;

   cbc_slot_timer #(
      .SLOT_BITS (SLOT_BITS)
   ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (enter_pre),
      .advance   ((state_q == ST_PRE) || (state_q == ST_DATA)),
      .in_window (in_window)
   );

   cbc_lfsr #(
      .LFSR_W (LFSR_W),
      .OUT_W  (BACKOFF_CAP),
      .SEED   (LFSR_SEED)
   ) u_rng (
      .clk   (clk),
      .rst_n (rst_n),
      .rnd   (lfsr_bits)
   );

   cbc_backoff_timer #(
      .SLOT_BITS   (SLOT_BITS),
      .BACKOFF_CAP (BACKOFF_CAP)
   ) u_backoff (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (back_load),
      .slots   (draw_val),
      .run     (state_q == ST_BACK),
      .expired (bo_expired)
   );

   assign att_next = (ATT_W + 1)'(att_q) + (ATT_W + 1)'(1);
   assign pre_last = (state_q == ST_PRE) && (idx_q == PRE_LAST);
   assign jam_last = (state_q == ST_JAM) && (idx_q == JAM_LAST);

   always_comb begin
      draw_exp = cap_exp(int'(att_next), BACKOFF_CAP);
      for (int b = 0; b < BACKOFF_CAP; b++)
         draw_mask[b] = (b < int'(draw_exp));
      draw_val = lfsr_bits & draw_mask;
   end

   always_comb begin
      state_d   = state_q;
      frame_ok  = 1'b0;
      abort_owc = 1'b0;
      abort_exc = 1'b0;
      back_load = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (tx_start)
               state_d = ST_PRE;
         end
         ST_PRE: begin
            if (pre_last)
               state_d = (col_pend_q || col_det) ? ST_JAM : ST_DATA;
         end
         ST_DATA: begin
            if (col_det) begin
               state_d = ST_JAM;
            end else if (tx_done) begin
               state_d  = ST_IDLE;
               frame_ok = 1'b1;
            end
         end
         ST_JAM: begin
            if (jam_last) begin
               if (owc_pend_q) begin
                  state_d   = ST_IDLE;
                  abort_owc = 1'b1;
               end else if (att_next == ATT_STOP) begin
                  state_d   = ST_IDLE;
                  abort_exc = 1'b1;
               end else begin
                  state_d   = ST_BACK;
                  back_load = 1'b1;
               end
            end
         end
         ST_BACK: begin
            if (bo_expired && (ack_seen_q || rtx_ack))
               state_d = ST_PRE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   assign enter_pre = (state_d == ST_PRE) && (state_q != ST_PRE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         idx_q      <= '0;
         col_pend_q <= 1'b0;
         owc_pend_q <= 1'b0;
         ack_seen_q <= 1'b0;
         att_q      <= '0;
         st_owc_q   <= 1'b0;
         st_exc_q   <= 1'b0;
         txe_q      <= 1'b0;
         tx_ok_q    <= 1'b0;
         slots_q    <= '0;
      end else begin
         state_q <= state_d;

         if (state_d != state_q)
            idx_q <= '0;
         else if ((state_q == ST_PRE) || (state_q == ST_JAM))
            idx_q <= idx_q + 1'b1;

         if (enter_pre)
            col_pend_q <= 1'b0;
         else if ((state_q == ST_PRE) && col_det)
            col_pend_q <= 1'b1;

         if (enter_pre)
            owc_pend_q <= 1'b0;
         else if (col_det && (((state_q == ST_PRE) && !col_pend_q) || (state_q == ST_DATA)))
            owc_pend_q <= !in_window;

         if (back_load)
            ack_seen_q <= 1'b0;
         else if ((state_q == ST_BACK) && rtx_ack)
            ack_seen_q <= 1'b1;

         if (frame_ok || abort_owc || abort_exc)
            att_q <= '0;
         else if (back_load)
            att_q <= att_next[ATT_W-1:0];

         if ((state_q == ST_IDLE) && tx_start) begin
            st_owc_q <= 1'b0;
            st_exc_q <= 1'b0;
         end else begin
            if (abort_owc) st_owc_q <= 1'b1;
            if (abort_exc) st_exc_q <= 1'b1;
         end

         txe_q   <= abort_owc || abort_exc;
         tx_ok_q <= frame_ok;

         if (back_load)
            slots_q <= draw_val;
      end
   end

   always_comb begin
      line_en  = (state_q == ST_PRE) || (state_q == ST_DATA) || (state_q == ST_JAM);
      line_bit = 1'b0;
      if (state_q == ST_PRE)
         line_bit = preamble_bit(int'(idx_q), PRE_BITS);
      else if (state_q == ST_JAM)
         line_bit = 1'b1;
   end

   assign mac_sel       = (state_q == ST_DATA);
   assign rtx_req       = (state_q == ST_BACK) && !ack_seen_q;
   assign txe           = txe_q;
   assign tx_ok         = tx_ok_q;
   assign st_owc        = st_owc_q;
   assign st_exc        = st_exc_q;
   assign attempt_cnt   = att_q;
   assign backoff_slots = slots_q;
endmodule

// File: rtl/cbc_checker.sv
module cbc_checker
   import cbc_pkg::*;
#(
   parameter int unsigned ATTEMPT_LIMIT = 16,
   parameter int unsigned BACKOFF_CAP   = 10
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             rtx_ack,
   input logic                             line_en,
   input logic                             line_bit,
   input logic                             mac_sel,
   input logic                             rtx_req,
   input logic                             txe,
   input logic                             tx_ok,
   input logic                             st_owc,
   input logic                             st_exc,
   input logic [$clog2(ATTEMPT_LIMIT)-1:0] attempt_cnt,
   input logic [BACKOFF_CAP-1:0]           backoff_slots,
   input cbc_state_e                       state_q
);
   AST_REQ_LINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      rtx_req |-> !line_en);  // R7

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (rtx_req && !rtx_ack) |=> rtx_req);  // R7

   AST_JAM_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_JAM) |-> (line_en && line_bit && !mac_sel));  // R3

   AST_MAC_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      mac_sel |-> line_en);  // R2

   AST_TXE_NOT_OK: assert property (@(posedge clk) disable iff (!rst_n)
      txe |-> !tx_ok);  // R12

   AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      rtx_req |-> ((int'(backoff_slots) >>
         cap_exp(int'(attempt_cnt), BACKOFF_CAP)) == 0));  // R5

   AST_OWC_NO_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_owc) |-> (!rtx_req && (attempt_cnt == '0) && txe));  // R8

   AST_EXC_NO_BACKOFF: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_exc) |-> (!rtx_req && (attempt_cnt == '0) && txe));  // R9

   AST_OK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ok |-> ((attempt_cnt == '0) && !line_en));  // R10
endmodule

bind col_backoff_ctrl cbc_checker #(
   .ATTEMPT_LIMIT (ATTEMPT_LIMIT),
   .BACKOFF_CAP   (BACKOFF_CAP)
) u_cbc_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .rtx_ack       (rtx_ack),
   .line_en       (line_en),
   .line_bit      (line_bit),
   .mac_sel       (mac_sel),
   .rtx_req       (rtx_req),
   .txe           (txe),
   .tx_ok         (tx_ok),
   .st_owc        (st_owc),
   .st_exc        (st_exc),
   .attempt_cnt   (attempt_cnt),
   .backoff_slots (backoff_slots),
   .state_q       (state_q)
);

// File: tb/col_backoff_ctrl_tb_top.sv
module col_backoff_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int SLOT  = 128;
   localparam int CAP   = 4;
   localparam int PRE   = 64;
   localparam int JAM   = 32;
   localparam int LIMIT = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_start = 1'b0, tx_done = 1'b0, col_det = 1'b0, rtx_ack = 1'b1;
   logic line_en, line_bit, mac_sel, rtx_req, txe, tx_ok, st_owc, st_exc;
   logic [3:0] attempt_cnt;
   logic [CAP-1:0] backoff_slots;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit finished = 1'b0;

   col_backoff_ctrl #(
      .SLOT_BITS   (SLOT),
      .BACKOFF_CAP (CAP)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .tx_start (tx_start), .tx_done (tx_done),
      .col_det (col_det), .rtx_ack (rtx_ack), .line_en (line_en),
      .line_bit (line_bit), .mac_sel (mac_sel), .rtx_req (rtx_req),
      .txe (txe), .tx_ok (tx_ok), .st_owc (st_owc), .st_exc (st_exc),
      .attempt_cnt (attempt_cnt), .backoff_slots (backoff_slots)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic start_frame();
      tx_start = 1'b1;
      step();
      tx_start = 1'b0;
   endtask

   // Checks the full preamble; pulses col_det during bit col_at (or never if < 0).
   task automatic run_preamble(input int col_at, input string req);
      int bad = 0;
      for (int i = 0; i < PRE; i++) begin
         logic expb;
         expb = (i == PRE - 1) ? 1'b1 : ((i % 2) == 0);
         if (!line_en || mac_sel || line_bit !== expb) bad++;
         if (i == col_at) col_det = 1'b1;
         step();
         col_det = 1'b0;
      end
      chk(bad == 0, req, bad, 0);
   endtask

   task automatic run_jam(input string req);
      int bad = 0;
      for (int i = 0; i < JAM; i++) begin
         if (!(line_en && line_bit && !mac_sel)) bad++;
         step();
      end
      chk(bad == 0, req, bad, 0);
   endtask

   task automatic measure_gap(output int gap);
      gap = 0;
      while (!line_en) begin
         gap++;
         step();
      end
   endtask

   task automatic finish_ok(input string req);
      step(5);
      tx_done = 1'b1;
      step();
      tx_done = 1'b0;
      chk(tx_ok && !line_en && attempt_cnt == 0, req, {tx_ok, line_en}, 2);
   endtask

   task automatic t_reset();
      step(3);
      chk(!line_en && !mac_sel && !rtx_req && !txe && !tx_ok && !st_owc && !st_exc
          && attempt_cnt == 0, "R1 during reset", int'(line_en), 0);
      rst_n = 1'b1;
      step();
      chk(!line_en && !rtx_req && !st_owc && !st_exc && attempt_cnt == 0,
          "R1 after reset", int'(attempt_cnt), 0);
   endtask

   task automatic t_clean_frame();
      start_frame();
      run_preamble(-1, "R2 preamble pattern");
      chk(mac_sel && line_en, "R2 mac_sel after preamble", int'(mac_sel), 1);
      finish_ok("R10 clean completion");
      step();
      chk(!tx_ok, "R10 tx_ok single pulse", int'(tx_ok), 0);
   endtask

   task automatic t_preamble_collision();
      int s, gap;
      start_frame();
      run_preamble(10, "R3 preamble completes after collision");
      run_jam("R3 jam after preamble");
      chk(!line_en && rtx_req && attempt_cnt == 1, "R5 retry request n=1",
          int'(attempt_cnt), 1);
      s = int'(backoff_slots);
      chk(s < 2, "R5 backoff range n=1", s, 1);
      measure_gap(gap);
      chk(gap == s * SLOT + 1, "R6 backoff gap", gap, s * SLOT + 1);
      run_preamble(-1, "R6 automatic retransmission preamble");
      finish_ok("R10 completion after retry");
   endtask

   task automatic t_window_edge_in();
      int s, gap;
      start_frame();
      run_preamble(-1, "R2 preamble");
      step(SLOT - 1 - PRE);         // now at bit time SLOT-1
      col_det = 1'b1;
      step();
      col_det = 1'b0;
      run_jam("R4 jam right after data collision");
      chk(rtx_req && !st_owc && attempt_cnt == 1, "R5 collision at slot-1 in-window",
          int'(st_owc), 0);
      measure_gap(gap);
      run_preamble(0, "R3 second attempt preamble");
      run_jam("R3 second jam");
      s = int'(backoff_slots);
      chk(rtx_req && attempt_cnt == 2, "R5 attempt count 2", int'(attempt_cnt), 2);
      chk(s < 4, "R5 backoff range n=2", s, 3);
      measure_gap(gap);
      chk(gap == s * SLOT + 1, "R6 backoff gap n=2", gap, s * SLOT + 1);
      run_preamble(-1, "R2 third attempt preamble");
      finish_ok("R10 completion clears count");
   endtask

   task automatic t_late_collision();
      int quiet = 0;
      start_frame();
      run_preamble(-1, "R2 preamble");
      step(SLOT - PRE);             // now at bit time SLOT
      col_det = 1'b1;
      step();
      col_det = 1'b0;
      run_jam("R4 jam on late collision");
      chk(!line_en && !rtx_req && st_owc && txe && attempt_cnt == 0 && !st_exc,
          "R8 out-of-window abort", {st_owc, txe, rtx_req}, 6);
      step();
      chk(!txe && st_owc, "R8 txe single pulse, status held", int'(txe), 0);
      for (int i = 0; i < 20; i++) begin
         if (line_en || rtx_req) quiet++;
         step();
      end
      chk(quiet == 0, "R8 no retry after late collision", quiet, 0);
      chk(st_owc, "R11 status held while idle", int'(st_owc), 1);
   endtask

   task automatic t_status_clear();
      start_frame();
      chk(!st_owc && !st_exc && line_en, "R11 status cleared by start", int'(st_owc), 0);
      run_preamble(-1, "R2 preamble");
      finish_ok("R10 completion");
   endtask

   task automatic t_ack_delay();
      int bad = 0;
      rtx_ack = 1'b0;
      start_frame();
      run_preamble(5, "R3 preamble with collision");
      run_jam("R3 jam");
      for (int i = 0; i < 3 * SLOT; i++) begin
         if (!rtx_req || line_en) bad++;
         step();
      end
      chk(bad == 0, "R7 hold without ack", bad, 0);
      rtx_ack = 1'b1;
      step();
      chk(line_en && line_bit && !rtx_req, "R7 restart after ack", int'(line_en), 1);
      run_preamble(-1, "R7 preamble after ack");
      finish_ok("R10 completion");
   endtask

   task automatic t_done_and_col();
      int gap;
      start_frame();
      run_preamble(-1, "R2 preamble");
      step(10);
      col_det = 1'b1;
      tx_done = 1'b1;
      step();
      col_det = 1'b0;
      tx_done = 1'b0;
      chk(!tx_ok && line_en && line_bit && !mac_sel, "R12 collision beats done",
          int'(tx_ok), 0);
      run_jam("R12 jam after simultaneous done");
      chk(rtx_req && attempt_cnt == 1, "R12 retry requested", int'(attempt_cnt), 1);
      measure_gap(gap);
      run_preamble(-1, "R2 retry preamble");
      finish_ok("R10 completion");
   endtask

   task automatic t_excessive();
      int gap;
      int bad_cnt = 0;
      start_frame();
      for (int n = 1; n <= LIMIT; n++) begin
         run_preamble(0, "R3 preamble in excessive run");
         run_jam("R3 jam in excessive run");
         if (n < LIMIT) begin
            if (!(rtx_req && attempt_cnt == n)) bad_cnt++;
            measure_gap(gap);
         end
      end
      chk(bad_cnt == 0, "R5 count rises each retry", bad_cnt, 0);
      chk(st_exc && txe && !rtx_req && !line_en && attempt_cnt == 0 && !st_owc,
          "R9 excessive collision abort", {st_exc, txe, rtx_req}, 6);
      step(SLOT);
      chk(!line_en && !rtx_req && st_exc, "R9 no backoff or retry", int'(line_en), 0);
   endtask

   initial begin
      t_reset();
      t_clean_frame();
      t_preamble_collision();
      t_window_edge_in();
      t_late_collision();
      t_status_clear();
      t_ack_delay();
      t_done_and_col();
      t_excessive();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule